// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block is a small, fully associative store of recent virtual-page-to-frame translations, placed in front of the page-table lookup path of a memory-management unit. A requester presents a virtual address. The block splits off the page number and compares it against every stored entry in the same cycle. On a hit, the block returns the physical address in that same cycle. The physical address is the stored frame number with the original page offset appended, and the offset is not changed.

On a miss, the block raises a request toward an external page-table lookup path. The request carries the missing page number. The block then refuses new lookups until that path answers with a frame number. The answer is written into a free entry if one exists. Otherwise it replaces the entry that has gone longest without use. The requester keeps its address on the bus and sees a hit once the new entry is in place.

A flush input empties the whole buffer in one cycle. It is meant for the moment the page-table base changes at a context switch.

Top module: `tlb_fa`

## Requirements
- R1: A lookup is accepted when `req_valid_i` and `req_ready_o` are both high. An accepted lookup whose page number (address bits above the offset) equals the tag of a valid entry raises `rsp_hit_o` in the same cycle. At most one entry ever matches.
- R2: A hit returns the stored frame and raises no page-table request.
- R3: An accepted lookup that matches no valid entry raises `miss_req_o` from the next cycle on. In that cycle `miss_vpn_o` shows the missing page number. Both stay unchanged until a refill is taken.
- R4: While `miss_req_o` is high, a cycle with `refill_valid_i` high installs the page number from `miss_vpn_o` together with `refill_pfn_i`, and drops `miss_req_o` in the next cycle. From that cycle on, a lookup of that page hits.
- R5: While any entry is invalid, a refill fills an invalid entry and evicts no valid one. After N distinct refills, all N pages hit.
- R6: When every entry is valid, a refill replaces the entry that was least recently hit or installed.
- R7: A hit makes its entry the most recently used. An installed entry also becomes the most recently used.
- R8: On a hit, `rsp_paddr_o` equals the stored frame number in the upper bits, followed by the lower OFF_W bits of `req_vaddr_i` unchanged.
- R9: After reset, no entry is valid, `miss_req_o` is low and `req_ready_o` is high.
- R10: A cycle with `flush_i` high clears every entry. In that cycle `req_ready_o` is low, so no lookup is taken. Every page looked up afterwards misses until it is refilled.
- R11: While a refill is pending, `req_ready_o` is low and no hit is reported, even for a page that is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| req_valid_i | input | 1 | Lookup request present |
| req_vaddr_i | input | VPN_W+OFF_W | Virtual address: page number above, offset below |
| req_ready_o | output | 1 | Lookup can be taken this cycle |
| rsp_hit_o | output | 1 | Accepted lookup hit |
| rsp_paddr_o | output | PFN_W+OFF_W | Translated address on a hit, zero otherwise |
| miss_req_o | output | 1 | Page-table lookup needed |
| miss_vpn_o | output | VPN_W | Page number to look up |
| refill_valid_i | input | 1 | Page-table answer present |
| refill_pfn_i | input | PFN_W | Frame number of the answer |

## Verification
The bound checker watches, on every cycle, the properties that are local in time. These are the single-match rule, the offset pass-through, the miss request and its page number staying fixed until a refill, the request dropping after the refill, the stall while a refill is pending, and the absence of hits right after a flush. The bench adds what only a sequence of lookups can show. That covers which entry the replacement picks once the buffer is full, that free entries are used before any valid one is replaced, that a hit refreshes an entry's age, and that an installed page hits afterwards. Each of these is measured against a reference model that keeps a timestamp per entry.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Controller mode: serving lookups, or waiting for a page-table answer
    typedef enum logic {
        MODE_LOOKUP = 1'b0,
        MODE_REFILL = 1'b1
    } tlb_mode_e;

endpackage

// File: rtl/tlb_match.sv
// Parallel tag compare across all entries, with an index encoder
module tlb_match #(
    parameter int N     = 4,
    parameter int VPN_W = 20,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]            valid_i,
    input  logic [N-1:0][VPN_W-1:0] tag_i,
    input  logic [VPN_W-1:0]        vpn_i,
    output logic [N-1:0]            hit_vec_o,
    output logic                    hit_any_o,
    output logic [IDX_W-1:0]        hit_idx_o
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec_o[g] = valid_i[g] && (tag_i[g] == vpn_i);
    end

    assign hit_any_o = |hit_vec_o;

    always_comb begin
        hit_idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec_o[i]) begin
                hit_idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlb_lru.sv
// Age-counter LRU: age 0 is most recent, N-1 is the oldest.
// The ages always form a permutation of 0..N-1.
module tlb_lru #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0][IDX_W-1:0] age_i,
    input  logic                    touch_i,
    input  logic [IDX_W-1:0]        touch_idx_i,
    input  logic [N-1:0]            valid_i,
    output logic [N-1:0][IDX_W-1:0] age_o,
    output logic [IDX_W-1:0]        victim_o
);

    logic [IDX_W-1:0] ref_age;
    logic [IDX_W-1:0] free_idx;
    logic             free_found;
    logic [IDX_W-1:0] old_idx;

    always_comb begin
        ref_age = age_i[touch_idx_i];
        for (int i = 0; i < N; i++) begin
            age_o[i] = age_i[i];
            if (touch_i) begin
                if (IDX_W'(i) == touch_idx_i) begin
                    age_o[i] = '0;
                end else if (age_i[i] < ref_age) begin
                    age_o[i] = age_i[i] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        free_idx   = '0;
        free_found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!valid_i[i] && !free_found) begin
                free_idx   = IDX_W'(i);
                free_found = 1'b1;
            end
        end
        old_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (age_i[i] == IDX_W'(N - 1)) begin
                old_idx = IDX_W'(i);
            end
        end
        victim_o = free_found ? free_idx : old_idx;
    end

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
    parameter int VPN_W = 20,
    parameter int OFF_W = 12,
    parameter int PFN_W = 16,
    parameter int N     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush_i,
    input  logic                   req_valid_i,
    input  logic [VPN_W+OFF_W-1:0] req_vaddr_i,
    output logic                   req_ready_o,
    output logic                   rsp_hit_o,
    output logic [PFN_W+OFF_W-1:0] rsp_paddr_o,
    output logic                   miss_req_o,
    output logic [VPN_W-1:0]       miss_vpn_o,
    input  logic                   refill_valid_i,
    input  logic [PFN_W-1:0]       refill_pfn_i
);
    import tlb_pkg::*;

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam int VA_W  = VPN_W + OFF_W;

    typedef struct packed {
        logic [N-1:0]            valid;
        logic [N-1:0][VPN_W-1:0] tag;
        logic [N-1:0][PFN_W-1:0] pfn;
        logic [N-1:0][IDX_W-1:0] age;
        tlb_mode_e               mode;
        logic [VPN_W-1:0]        miss_vpn;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int i = 0; i < N; i++) begin
            s.age[i] = IDX_W'(i);
        end
        s.mode = MODE_LOOKUP;
        return s;
    endfunction

    state_t s_d, s_q;

    logic [VPN_W-1:0]        req_vpn;
    logic [OFF_W-1:0]        req_off;
    logic [N-1:0]            hit_vec;
    logic                    hit_any;
    logic [IDX_W-1:0]        hit_idx;
    logic [N-1:0]            valid_kept;
    logic                    lookup_fire;
    logic                    hit_fire;
    logic                    install;
    logic                    lru_touch;
    logic [IDX_W-1:0]        lru_idx;
    logic [N-1:0][IDX_W-1:0] age_next;
    logic [IDX_W-1:0]        victim;

    assign req_vpn = req_vaddr_i[VA_W-1:OFF_W];
    assign req_off = req_vaddr_i[OFF_W-1:0];

    tlb_match #(.N(N), .VPN_W(VPN_W), .IDX_W(IDX_W)) match_i (
        .valid_i   (s_q.valid),
        .tag_i     (s_q.tag),
        .vpn_i     (req_vpn),
        .hit_vec_o (hit_vec),
        .hit_any_o (hit_any),
        .hit_idx_o (hit_idx)
    );

    tlb_lru #(.N(N), .IDX_W(IDX_W)) lru_i (
        .age_i       (s_q.age),
        .touch_i     (lru_touch),
        .touch_idx_i (lru_idx),
        .valid_i     (valid_kept),
        .age_o       (age_next),
        .victim_o    (victim)
    );

    always_comb begin
        req_ready_o = (s_q.mode == MODE_LOOKUP) && !flush_i;
        lookup_fire = req_valid_i && req_ready_o;
        hit_fire    = lookup_fire && hit_any;
        install     = (s_q.mode == MODE_REFILL) && refill_valid_i;
        valid_kept  = flush_i ? '0 : s_q.valid;
        lru_touch   = hit_fire || install;
        lru_idx     = install ? victim : hit_idx;

        s_d       = s_q;
        s_d.valid = valid_kept;
        s_d.age   = age_next;
        if (install) begin
            s_d.valid[victim] = 1'b1;
            s_d.tag[victim]   = s_q.miss_vpn;
            s_d.pfn[victim]   = refill_pfn_i;
            s_d.mode          = MODE_LOOKUP;
        end else if (lookup_fire && !hit_any) begin
            s_d.mode     = MODE_REFILL;
            s_d.miss_vpn = req_vpn;
        end

        rsp_hit_o   = hit_fire;
        rsp_paddr_o = hit_fire ? {s_q.pfn[hit_idx], req_off} : '0;
        miss_req_o  = (s_q.mode == MODE_REFILL);
        miss_vpn_o  = s_q.miss_vpn;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= reset_state();
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
    parameter int VPN_W = 20,
    parameter int OFF_W = 12,
    parameter int PFN_W = 16,
    parameter int N     = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   flush_i,
    input logic                   req_valid_i,
    input logic [VPN_W+OFF_W-1:0] req_vaddr_i,
    input logic                   req_ready_o,
    input logic                   rsp_hit_o,
    input logic [PFN_W+OFF_W-1:0] rsp_paddr_o,
    input logic                   miss_req_o,
    input logic [VPN_W-1:0]       miss_vpn_o,
    input logic                   refill_valid_i,
    input logic [N-1:0]           hit_vec
);
    localparam int VA_W = VPN_W + OFF_W;

    p_onehot_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    p_hit_no_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit_o |=> !miss_req_o);

    p_miss_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && !rsp_hit_o) |=>
            (miss_req_o && miss_vpn_o == $past(req_vaddr_i[VA_W-1:OFF_W])));

    p_miss_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req_o && !refill_valid_i) |=> (miss_req_o && $stable(miss_vpn_o)));

    p_refill_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req_o && refill_valid_i) |=> !miss_req_o);

    p_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit_o |-> (rsp_paddr_o[OFF_W-1:0] == req_vaddr_i[OFF_W-1:0]));

    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && !(miss_req_o && refill_valid_i)) |=> !rsp_hit_o);

    p_flush_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> !req_ready_o);

    p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req_o |-> (!req_ready_o && !rsp_hit_o));

    p_reset_r9: assert property (@(posedge clk)
        $rose(rst_n) |-> (!miss_req_o && req_ready_o == !flush_i));

endmodule

bind tlb_fa tlb_fa_chk #(
    .VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .N(N)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush_i        (flush_i),
    .req_valid_i    (req_valid_i),
    .req_vaddr_i    (req_vaddr_i),
    .req_ready_o    (req_ready_o),
    .rsp_hit_o      (rsp_hit_o),
    .rsp_paddr_o    (rsp_paddr_o),
    .miss_req_o     (miss_req_o),
    .miss_vpn_o     (miss_vpn_o),
    .refill_valid_i (refill_valid_i),
    .hit_vec        (hit_vec)
);

// File: tb/tlb_fa_tb_top.sv
`timescale 1ns/1ps
module tlb_fa_tb_top;
    localparam int VPN_W = 20;
    localparam int OFF_W = 12;
    localparam int PFN_W = 16;
    localparam int N     = 4;
    localparam int VA_W  = VPN_W + OFF_W;
    localparam int PA_W  = PFN_W + OFF_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush_i = 1'b0;
    logic             req_valid_i = 1'b0;
    logic [VA_W-1:0]  req_vaddr_i = '0;
    logic             req_ready_o;
    logic             rsp_hit_o;
    logic [PA_W-1:0]  rsp_paddr_o;
    logic             miss_req_o;
    logic [VPN_W-1:0] miss_vpn_o;
    logic             refill_valid_i = 1'b0;
    logic [PFN_W-1:0] refill_pfn_i = '0;

    always #2 clk = ~clk;

    tlb_fa #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .N(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .req_valid_i(req_valid_i), .req_vaddr_i(req_vaddr_i),
        .req_ready_o(req_ready_o), .rsp_hit_o(rsp_hit_o), .rsp_paddr_o(rsp_paddr_o),
        .miss_req_o(miss_req_o), .miss_vpn_o(miss_vpn_o),
        .refill_valid_i(refill_valid_i), .refill_pfn_i(refill_pfn_i)
    );

    int total = 0;
    int bad   = 0;

    // Reference model: valid flag, tag, frame and a use timestamp per entry
    bit               mv[N];
    logic [VPN_W-1:0] mt[N];
    logic [PFN_W-1:0] mp[N];
    int               ms[N];
    bit               mpend = 0;
    logic [VPN_W-1:0] mpv = '0;
    int               stampc = 0;

    logic             last_hit;
    logic [PA_W-1:0]  last_paddr;

    function automatic logic [PFN_W-1:0] pfn_of(input logic [VPN_W-1:0] v);
        return PFN_W'(v * 7 + 3);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic fl, input logic rv, input logic [VA_W-1:0] va,
                        input logic fv, input logic [PFN_W-1:0] fp);
        bit ready, found, e_hit;
        int idx, vic, best;
        logic [VPN_W-1:0] vpn;
        @(negedge clk);
        flush_i = fl; req_valid_i = rv; req_vaddr_i = va;
        refill_valid_i = fv; refill_pfn_i = fp;
        #1;
        vpn = va[VA_W-1:OFF_W];
        ready = !mpend && !fl;
        found = 0; idx = 0;
        for (int i = 0; i < N; i++) if (mv[i] && mt[i] == vpn) begin found = 1; idx = i; end
        e_hit = rv && ready && found;
        check("R11", "ready", 64'(req_ready_o), 64'(ready));
        check("R1", "hit", 64'(rsp_hit_o), 64'(e_hit));
        check("R3", "miss_req", 64'(miss_req_o), 64'(mpend));
        if (mpend) check("R3", "miss_vpn", 64'(miss_vpn_o), 64'(mpv));
        if (e_hit) check("R8", "paddr", 64'(rsp_paddr_o), 64'({mp[idx], va[OFF_W-1:0]}));
        last_hit = rsp_hit_o; last_paddr = rsp_paddr_o;
        // model update for this clock edge
        if (fl) for (int i = 0; i < N; i++) mv[i] = 0;
        if (mpend && fv) begin
            vic = -1;
            for (int i = 0; i < N; i++) if (!mv[i] && vic < 0) vic = i;
            if (vic < 0) begin
                best = 0;
                for (int i = 1; i < N; i++) if (ms[i] < ms[best]) best = i;
                vic = best;
            end
            mv[vic] = 1; mt[vic] = mpv; mp[vic] = fp; ms[vic] = ++stampc;
            mpend = 0;
        end else if (e_hit) begin
            ms[idx] = ++stampc;
        end else if (rv && ready && !found) begin
            mpend = 1; mpv = vpn;
        end
    endtask

    task automatic look(input logic [VPN_W-1:0] v, input logic [OFF_W-1:0] off,
                        input logic exp_hit, input string req);
        step(0, 1, {v, off}, 0, '0);
        check(req, "scenario hit", 64'(last_hit), 64'(exp_hit));
        if (exp_hit) check(req, "scenario paddr", 64'(last_paddr), 64'({pfn_of(v), off}));
    endtask

    // Miss, one stalled cycle, refill, then the same lookup hits (R4)
    task automatic serve(input logic [VPN_W-1:0] v, input string req);
        look(v, 12'h010, 0, req);
        step(0, 1, {v, 12'h010}, 0, '0);
        check("R11", "stall ready", 64'(req_ready_o), 64'(0));
        step(0, 1, {v, 12'h010}, 1, pfn_of(v));
        look(v, 12'h010, 1, "R4");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [VPN_W-1:0] pool[6];
        logic [VA_W-1:0]  cur_va;
        int               wait_c;
        for (int i = 0; i < N; i++) begin mv[i] = 0; ms[i] = 0; end
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check("R9", "ready after reset", 64'(req_ready_o), 64'(1));
        check("R9", "miss after reset", 64'(miss_req_o), 64'(0));

        // R5: fill an empty buffer with four pages
        serve(20'h00011, "R9");
        serve(20'h00022, "R5");
        serve(20'h00033, "R5");
        serve(20'h00044, "R5");
        look(20'h00011, 12'h000, 1, "R5");
        look(20'h00022, 12'hFFF, 1, "R5");
        look(20'h00033, 12'h5A5, 1, "R8");
        look(20'h00044, 12'h123, 1, "R8");
        // R7: refresh 0x11, so 0x22 becomes the oldest
        look(20'h00011, 12'h777, 1, "R7");
        serve(20'h00055, "R6");
        look(20'h00022, 12'h001, 0, "R6");
        // pending miss on 0x22: a present page is not served (R11)
        step(0, 1, {20'h00033, 12'h002}, 0, '0);
        check("R11", "no hit while pending", 64'(last_hit), 64'(0));
        step(0, 0, '0, 1, pfn_of(20'h00022));
        look(20'h00022, 12'h003, 1, "R4");
        // 0x33 was the oldest at that refill, so it is gone; 0x11 survives (R7)
        look(20'h00011, 12'h004, 1, "R7");
        look(20'h00033, 12'h005, 0, "R6");
        step(0, 0, '0, 1, pfn_of(20'h00033));

        // R10: flush, with a lookup offered in the flush cycle
        step(1, 1, {20'h00011, 12'h000}, 0, '0);
        check("R10", "ready in flush", 64'(last_hit), 64'(0));
        look(20'h00055, 12'h006, 0, "R10");
        step(0, 0, '0, 1, pfn_of(20'h00055));
        look(20'h00011, 12'h007, 0, "R10");
        step(0, 0, '0, 1, pfn_of(20'h00011));
        look(20'h00055, 12'h008, 1, "R4");

        // Mixed traffic against the model (R1 R6 R7)
        pool[0] = 20'h00011; pool[1] = 20'h00022; pool[2] = 20'h00033;
        pool[3] = 20'h00044; pool[4] = 20'h00055; pool[5] = 20'hABCDE;
        cur_va = '0; wait_c = 0;
        for (int k = 0; k < 600; k++) begin
            if (mpend) begin
                if (wait_c > 0) begin
                    wait_c--;
                    step(0, 1, cur_va, 0, '0);
                end else begin
                    step(0, 1, cur_va, 1, pfn_of(mpv));
                end
            end else begin
                cur_va = {pool[$urandom % 6], OFF_W'($urandom)};
                step(($urandom % 40) == 0, 1, cur_va, 0, '0);
                wait_c = $urandom % 3;
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule